// File: doc/BRIEF.md
# Receive FIFO Read Throttler

This block sits on the read side of a receive FIFO and owns its read-enable. The FIFO returns one beat per cycle while read-enable is high and it holds data. Each beat carries valid, start-of-packet and end-of-packet flags. The block reads steadily and counts the frames that complete. After a programmed number of frames it stops reading on purpose. That lets the FIFO fill up, so the upstream flow-control logic (for example a pause-frame sender watching the fill level) gets exercised.

After it stops, the block keeps read-enable low for a programmed number of clock cycles. It then reads again, without pause, until the FIFO reports empty. When the drain finishes, the block clears its frame count and starts a new throttling round. A stop count of zero turns throttling off, and the block then reads forever. A two-bit phase output shows which state the controller is in.

The controller has three states:
- `PH_READ` (code 0): normal reading.
- `PH_HOLD` (code 1): reads withheld.
- `PH_DRAIN` (code 2): reading until empty.

It has four transitions:
- *stop-to-hold*: READ to HOLD, on the completing end-of-packet when the hold count is non-zero.
- *stop-to-drain*: READ to DRAIN, on that end-of-packet when the hold count is zero.
- *hold-expire*: HOLD to DRAIN, after the last hold cycle.
- *drain-done*: DRAIN to READ, when empty is seen.

Top module: `rx_read_throttler`

## Requirements
- R1: A frame is counted on a beat where `rxq_valid`, `rxq_rd_en` and `rxq_eop` are all high. When the count reaches `cfg_stop_frames` (non-zero) on such a beat, `rxq_rd_en` is low in the next cycle, or the phase becomes 2 if the hold count is zero.
- R2: With `cfg_stop_frames` = 0, `rxq_rd_en` stays high and `rd_phase` stays 0 (READ) for any frame traffic, and `cfg_hold_cycles` has no effect.
- R3: After a stop with `cfg_hold_cycles` = H > 0, `rxq_rd_en` is low for exactly H consecutive cycles with `rd_phase` = 1 (HOLD). With H = 0 the hold state is skipped.
- R4: After the hold, `rd_phase` = 2 (DRAIN) with `rxq_rd_en` high in every cycle until a cycle in which `rxq_empty` is high. In the following cycle `rd_phase` returns to 0.
- R5: The drain-done transition clears the frame count, so the next stop comes after exactly `cfg_stop_frames` further frames.
- R6: An end-of-packet beat is counted only if a start-of-packet beat opened its frame, or the same beat carries start-of-packet. An end-of-packet with no opening start is not counted.
- R7: After reset, `rxq_rd_en` is high and `rd_phase` is 0.
- R8: `rxq_rd_en` is low only while `rd_phase` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO read clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_stop_frames | input | FRAME_W | Frames read before a stop; 0 disables throttling |
| cfg_hold_cycles | input | HOLD_W | Cycles with reads withheld after a stop |
| rxq_empty | input | 1 | FIFO holds no data |
| rxq_valid | input | 1 | Beat returned by the FIFO is valid |
| rxq_sop | input | 1 | Beat opens a frame |
| rxq_eop | input | 1 | Beat closes a frame |
| rxq_rd_en | output | 1 | Read-enable to the FIFO |
| rd_phase | output | 2 | 0 READ, 1 HOLD, 2 DRAIN |

## Verification
Two functions can fall in the same cycle: counting a frame and taking the stop decision. The end-of-packet beat that completes the stop count is also the beat that triggers the stop, and with one-beat frames and a stop count of one, every beat both opens and closes a frame. The bench sweeps stop count, hold length and frame length, including one-beat frames, and judges each run by where the first withheld cycle falls in the beat count. A second coincidence is the counter clear on drain-done followed at once by a fresh batch of frames. The bench checks that the next stop lands after exactly the programmed number of frames.

// File: rtl/rxthr_pkg.sv
`timescale 1ns/1ps
package rxthr_pkg;
    typedef enum logic [1:0] {
        PH_READ  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_DRAIN = 2'd2
    } rxthr_phase_e;
endpackage

// File: rtl/rxthr_frame_counter.sv
`timescale 1ns/1ps
module rxthr_frame_counter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_valid,
    input  logic               beat_sop,
    input  logic               beat_eop,
    input  logic               clear,
    input  logic [FRAME_W-1:0] stop_frames,
    output logic               stop_hit
);
    localparam logic [FRAME_W-1:0] CNT_MAX = {FRAME_W{1'b1}};

    logic [FRAME_W-1:0] cnt_q;
    logic               in_frame_q;
    logic               frame_done;
    logic [FRAME_W:0]   cnt_plus;

    // A frame completes only if it was opened by a start beat (R6)
    assign frame_done = beat_valid && beat_eop && (in_frame_q || beat_sop);
    assign cnt_plus   = {1'b0, cnt_q} + 1'b1;
    assign stop_hit   = frame_done && (stop_frames != '0)
                        && (cnt_plus == {1'b0, stop_frames});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
        end else if (beat_valid) begin
            if (beat_eop) begin
                in_frame_q <= 1'b0;
            end else if (beat_sop) begin
                in_frame_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (frame_done && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
    assert_frame_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !clear && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_orphan_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_eop && !beat_sop && !in_frame_q && !clear) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/rxthr_hold_timer.sv
`timescale 1ns/1ps
module rxthr_hold_timer #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              running,
    output logic              last
);
    logic [HOLD_W-1:0] cnt_q;

    assign last = running && (cnt_q <= HOLD_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (running && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_hold_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !last && !load) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rxthr_fsm.sv
`timescale 1ns/1ps
module rxthr_fsm
    import rxthr_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int HOLD_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_hit,
    input  logic [FRAME_W-1:0] stop_frames,
    input  logic [HOLD_W-1:0]  hold_cfg,
    input  logic               hold_last,
    input  logic               empty,
    output logic               hold_load,
    output logic               cnt_clear,
    output logic               hold_run,
    output logic               rd_en,
    output logic [1:0]         phase
);
    rxthr_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_READ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        hold_load = 1'b0;
        cnt_clear = 1'b0;
        unique case (state_q)
            PH_READ: begin
                if (stop_hit) begin
                    if (hold_cfg == '0) begin
                        state_d = PH_DRAIN;       // stop-to-drain
                    end else begin
                        state_d   = PH_HOLD;      // stop-to-hold
                        hold_load = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (hold_last) begin
                    state_d = PH_DRAIN;           // hold-expire
                end
            end
            PH_DRAIN: begin
                if (empty) begin
                    state_d   = PH_READ;          // drain-done
                    cnt_clear = 1'b1;
                end
            end
            default: state_d = PH_READ;
        endcase
    end

    always_comb begin
        rd_en    = (state_q != PH_HOLD);
        hold_run = (state_q == PH_HOLD);
        phase    = state_q;
    end

    assert_stop_leaves_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_READ && stop_hit) |=> state_q != PH_READ);
    assert_zero_stop_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_READ && stop_frames == '0) |=> state_q == PH_READ);
    assert_hold_persists_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HOLD && !hold_last) |=> state_q == PH_HOLD);
    assert_zero_hold_skips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_READ && stop_hit && hold_cfg == '0) |=> state_q == PH_DRAIN);
    assert_drain_until_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DRAIN && !empty) |=> state_q == PH_DRAIN);
    assert_drain_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DRAIN && empty) |=> state_q == PH_READ);
endmodule

// File: rtl/rx_read_throttler.sv
`timescale 1ns/1ps
module rx_read_throttler #(
    parameter int FRAME_W = 8,
    parameter int HOLD_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] cfg_stop_frames,
    input  logic [HOLD_W-1:0]  cfg_hold_cycles,
    input  logic               rxq_empty,
    input  logic               rxq_valid,
    input  logic               rxq_sop,
    input  logic               rxq_eop,
    output logic               rxq_rd_en,
    output logic [1:0]         rd_phase
);
    localparam logic [1:0] PHASE_HOLD = 2'd1;

    logic stop_hit;
    logic hold_load;
    logic hold_last;
    logic hold_run;
    logic cnt_clear;
    logic beat_taken;

    // Beats presented while reads are withheld are not ours
    assign beat_taken = rxq_valid && rxq_rd_en;

    rxthr_frame_counter #(.FRAME_W(FRAME_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_valid  (beat_taken),
        .beat_sop    (rxq_sop),
        .beat_eop    (rxq_eop),
        .clear       (cnt_clear),
        .stop_frames (cfg_stop_frames),
        .stop_hit    (stop_hit)
    );

    rxthr_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (cfg_hold_cycles),
        .running  (hold_run),
        .last     (hold_last)
    );

    rxthr_fsm #(.FRAME_W(FRAME_W), .HOLD_W(HOLD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_hit    (stop_hit),
        .stop_frames (cfg_stop_frames),
        .hold_cfg    (cfg_hold_cycles),
        .hold_last   (hold_last),
        .empty       (rxq_empty),
        .hold_load   (hold_load),
        .cnt_clear   (cnt_clear),
        .hold_run    (hold_run),
        .rd_en       (rxq_rd_en),
        .phase       (rd_phase)
    );

    assert_rd_low_only_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rxq_rd_en |-> rd_phase == PHASE_HOLD);
endmodule

// File: tb/rx_read_throttler_tb_top.sv
`timescale 1ns/1ps
module rx_read_throttler_tb_top;
    localparam int FRAME_W = 8;
    localparam int HOLD_W  = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [FRAME_W-1:0] cfg_stop_frames = '0;
    logic [HOLD_W-1:0]  cfg_hold_cycles = '0;
    logic               rxq_empty = 1'b1;
    logic               rxq_valid = 1'b0;
    logic               rxq_sop = 1'b0;
    logic               rxq_eop = 1'b0;
    logic               rxq_rd_en;
    logic [1:0]         rd_phase;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // FIFO model state
    int  beats_left = 0;
    int  flen = 1;
    int  pos = 0;
    bit  orphan = 1'b0;

    // Observations of the last step
    bit         o_rd;
    logic [1:0] o_ph;
    bit         o_beat;

    always #4 clk = ~clk;

    rx_read_throttler #(.FRAME_W(FRAME_W), .HOLD_W(HOLD_W)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_stop_frames (cfg_stop_frames),
        .cfg_hold_cycles (cfg_hold_cycles),
        .rxq_empty       (rxq_empty),
        .rxq_valid       (rxq_valid),
        .rxq_sop         (rxq_sop),
        .rxq_eop         (rxq_eop),
        .rxq_rd_en       (rxq_rd_en),
        .rd_phase        (rd_phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        o_rd   = rxq_rd_en;
        o_ph   = rd_phase;
        o_beat = o_rd && (beats_left > 0);
        rxq_valid = o_beat;
        rxq_sop   = o_beat && (pos == 0) && !orphan;
        rxq_eop   = o_beat && (pos == flen - 1);
        rxq_empty = (beats_left == 0);
        @(posedge clk);
        #1;
        if (o_beat) begin
            beats_left--;
            pos++;
            if (pos == flen) begin
                pos = 0;
                orphan = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rxq_valid = 1'b0;
        rxq_sop = 1'b0;
        rxq_eop = 1'b0;
        rxq_empty = 1'b1;
        beats_left = 0;
        pos = 0;
        orphan = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Read until `target` beats are taken; all must be in READ with rd_en high
    task automatic read_beats(input int target, output bit ok);
        int got = 0;
        int guard = 0;
        ok = 1'b1;
        while (got < target && guard < 5000) begin
            step();
            ok &= o_rd && (o_ph == 2'd0);
            if (o_beat) got++;
            guard++;
        end
        ok &= (got == target);
    endtask

    task automatic run_cfg(input int s, input int h, input int l);
        bit ok;
        cfg_stop_frames = FRAME_W'(s);
        cfg_hold_cycles = HOLD_W'(h);
        flen = l;
        do_reset();
        @(negedge clk);
        chk(rxq_rd_en == 1'b1 && rd_phase == 2'd0, "R7 reset state", int'(rd_phase), 0);
        if (s == 0) begin
            beats_left = 4 * l;
            read_beats(4 * l, ok);
            for (int i = 0; i < 4; i++) begin
                step();
                ok &= o_rd && (o_ph == 2'd0);
            end
            chk(ok, "R2 no throttle with zero stop", int'(o_ph), 0);
            return;
        end
        beats_left = (s + 2) * l;
        read_beats(s * l, ok);
        chk(ok, "R1 reads until stop count", int'(o_ph), 0);
        ok = 1'b1;
        for (int i = 0; i < h; i++) begin
            step();
            ok &= !o_rd && (o_ph == 2'd1);
        end
        chk(ok, "R3 hold length", int'(o_rd), 0);
        step();
        chk(o_rd && o_ph == 2'd2, "R3 hold ends into drain", int'(o_ph), 2);
        ok = 1'b1;
        for (int g = 0; g < 5000 && beats_left > 0; g++) begin
            step();
            ok &= o_rd && (o_ph == 2'd2);
        end
        step();
        ok &= o_rd && (o_ph == 2'd2) && !o_beat;
        chk(ok, "R4 drain until empty", int'(o_ph), 2);
        step();
        chk(o_ph == 2'd0, "R4 back to read after empty", int'(o_ph), 0);
        beats_left = (s + 1) * l;
        read_beats(s * l, ok);
        chk(ok, "R5 count restarts after drain", int'(o_ph), 0);
        step();
        if (h > 0) begin
            chk(!o_rd && o_ph == 2'd1, "R5 second stop", int'(o_rd), 0);
        end else begin
            chk(o_rd && o_ph == 2'd2, "R5 second stop no hold", int'(o_ph), 2);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok;
        for (int s = 0; s <= 3; s++) begin
            for (int h = 0; h <= 3; h++) begin
                for (int l = 1; l <= 3; l++) begin
                    run_cfg(s, h, l);
                end
            end
        end
        // Hold count large but stop zero: hold must be ignored (R2)
        run_cfg(0, 10, 2);
        // Orphan end-of-packet not counted (R6): stop=1, frame len 2
        cfg_stop_frames = FRAME_W'(1);
        cfg_hold_cycles = HOLD_W'(3);
        flen = 2;
        do_reset();
        orphan = 1'b1;
        beats_left = 8;
        read_beats(4, ok);
        chk(ok, "R6 orphan frame skipped", int'(o_ph), 0);
        step();
        chk(!o_rd && o_ph == 2'd1, "R6 stop after real frame", int'(o_rd), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule